// File: doc/BRIEF.md
# Multi-Bank Endpoint Status Controller

This block keeps the bank occupancy and the status flags of one USB device endpoint that owns between one and three packet buffers (banks). It serves either direction, selected by a configuration input. It sits between the packet engine, which reports single-cycle events such as "packet stored", "IN token" and "toggle error", and the firmware, which issues single-cycle strobes for "data read", "packet ready" and "kill bank". It presents a busy-bank count, the index of the bank that is served next, level status flags and per-flag interrupt requests.

The flags follow the banks rather than the strobes. A firmware clear of the received-data flag leaves it set while another bank still holds a packet. The packet-ready flag reads set only while every configured bank is full, and it drops when a transmission frees a bank. A kill request is held for exactly one cycle and is then settled against any IN token that arrives in that cycle. Either an endpoint reset strobe or an endpoint disable strobe returns everything to its reset value.

Top module: `ep_bank_status`

## Requirements
- R1: In the cycle after `ep_rst` or `ep_dis` is high, `busy_cnt` and `cur_bank` are 0 and every flag and interrupt output is low. Other events in that strobe cycle are ignored.
- R2: In OUT mode (`cfg_dir_in`=0), an accepted `pk_stored` raises `busy_cnt` by one and sets `rx_ready` after the next clock edge.
- R3: In OUT mode, `fw_rx_clr` frees the bank at `cur_bank` when `busy_cnt`>0. `rx_ready` stays high while at least one bank is still occupied and falls when the last one is freed.
- R4: The effective bank number is `cfg_banks` clamped to 1..MAX_BANKS, so 0 counts as 1. `busy_cnt` never exceeds it. A store into a full endpoint is dropped and leaves the count unchanged.
- R5: A dropped OUT packet sets the sticky `err_flow` only when `cfg_iso`=1.
- R6: In IN mode, `fw_tx_set` fills a free bank. `tx_ready` is high exactly when `busy_cnt` equals the effective bank number, so with free banks it stays low after a set. A set into a full endpoint is ignored.
- R7: In IN mode, `in_token` with `busy_cnt`>0 transmits the bank at `cur_bank`. The count drops by one and the sticky `tx_complete` is set.
- R8: In IN mode, `fw_kill` raises `kill_busy` for exactly one cycle, and a `fw_kill` while `kill_busy` is high is ignored. In that cycle, with no token, the most recently filled bank is removed if one exists; on an empty endpoint nothing is removed.
- R9: A kill settled in the same cycle as an `in_token` with one busy bank is refused. The packet is sent, the count becomes 0 and `tx_complete` is set. With two or more busy banks, the current bank is sent and the last-filled bank is killed, so the count drops by two.
- R10: In isochronous IN mode, `in_token` with `busy_cnt`=0 sets `err_flow`.
- R11: In isochronous OUT mode, `trans_err` is high while `busy_cnt`>0 and the bank at `cur_bank` was stored with `pk_tog_err`=1. It falls once `cur_bank` moves to a bank stored without the error.
- R12: `cur_bank` advances round-robin, wrapping from the effective bank number minus one to 0, on every OUT release and every IN transmission. A kill does not move it.
- R13: `irq` bit positions are 0 received data, 1 packet-ready cleared, 2 transmit complete, 3 transaction error and 4 error flow. Each bit is its flag ANDed with the matching `irq_en` bit. Bit 1 is a one-cycle pulse after a transmission clears `tx_ready`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ep_rst | input | 1 | Endpoint reset strobe |
| ep_dis | input | 1 | Endpoint disable strobe |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint |
| cfg_iso | input | 1 | Isochronous endpoint |
| cfg_banks | input | CNT_W | Configured bank number |
| irq_en | input | 5 | Per-flag interrupt enables |
| pk_stored | input | 1 | OUT packet received from host |
| pk_tog_err | input | 1 | The stored group had a toggle fault (with `pk_stored`) |
| fw_rx_clr | input | 1 | Firmware has read the OUT bank |
| fw_tx_set | input | 1 | Firmware filled an IN bank |
| fw_kill | input | 1 | Firmware kill request |
| in_token | input | 1 | IN token; sends the current bank if one is busy |
| rx_ready | output | 1 | Received data waiting |
| tx_ready | output | 1 | All IN banks full |
| tx_complete | output | 1 | An IN packet was sent (sticky) |
| kill_busy | output | 1 | Kill request being settled |
| trans_err | output | 1 | Current OUT bank holds a faulty group |
| err_flow | output | 1 | Isochronous underflow or overflow (sticky) |
| busy_cnt | output | CNT_W | Occupied banks |
| cur_bank | output | IDX_W | Bank served next |
| irq | output | 5 | Interrupt requests |

## Verification
The bench builds the block with MAX_BANKS=3, which gives a two-bit count and a two-bit bank index. Across its phases it drives `cfg_banks` through 0, 1, 2 and 3 in both directions, with and without isochronous mode. This covers the clamp of 0 to one bank, single-bank refusal of a kill, index wrap at 2 and at 3 banks, and the kill-plus-token case with two and three busy banks. A reference model in the bench follows every cycle of random traffic, and directed sequences pin the exact values of the corner cases.

// File: rtl/ebsc_pkg.sv
package ebsc_pkg;
    localparam int IRQ_W       = 5;
    localparam int IRQ_RX      = 0;
    localparam int IRQ_TXRDY   = 1;
    localparam int IRQ_TXDONE  = 2;
    localparam int IRQ_TRERR   = 3;
    localparam int IRQ_ERRFLOW = 4;
endpackage

// File: rtl/ebsc_out_path.sv
// OUT direction: release by firmware first, then try to store the new packet.
module ebsc_out_path #(
    parameter int CNT_W = 2
) (
    input  logic             en,
    input  logic [CNT_W-1:0] busy_q,
    input  logic [CNT_W-1:0] banks,
    input  logic             pk_stored,
    input  logic             fw_rx_clr,
    output logic             rel,
    output logic             acc,
    output logic             drop,
    output logic [CNT_W-1:0] cnt_mid,
    output logic [CNT_W-1:0] cnt_nxt
);
    always_comb begin
        rel     = en && fw_rx_clr && (busy_q != '0);
        cnt_mid = busy_q - CNT_W'(rel);
        acc     = en && pk_stored && (cnt_mid < banks);
        drop    = en && pk_stored && !acc;
        cnt_nxt = cnt_mid + CNT_W'(acc);
    end
endmodule

// File: rtl/ebsc_in_path.sv
// IN direction: transmission first, then the pending kill, then the firmware fill.
module ebsc_in_path #(
    parameter int CNT_W = 2
) (
    input  logic             en,
    input  logic [CNT_W-1:0] busy_q,
    input  logic [CNT_W-1:0] banks,
    input  logic             in_token,
    input  logic             kill_q,
    input  logic             fw_tx_set,
    output logic             sent,
    output logic             underrun,
    output logic [CNT_W-1:0] cnt_nxt
);
    logic [CNT_W-1:0] after_tx;
    logic [CNT_W-1:0] after_kill;
    logic             killed;
    logic             set_acc;

    always_comb begin
        sent       = en && in_token && (busy_q != '0);
        underrun   = en && in_token && (busy_q == '0);
        after_tx   = busy_q - CNT_W'(sent);
        // with one busy bank and a token, nothing is left to kill: refused
        killed     = en && kill_q && (after_tx != '0);
        after_kill = after_tx - CNT_W'(killed);
        set_acc    = en && fw_tx_set && (after_kill < banks);
        cnt_nxt    = after_kill + CNT_W'(set_acc);
    end
endmodule

// File: rtl/ebsc_bank_ring.sv
// Round-robin bank pointer plus one toggle-fault bit per bank.
module ebsc_bank_ring #(
    parameter int MAX_BANKS = 3,
    parameter int CNT_W     = 2,
    parameter int IDX_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] banks,
    input  logic             adv,
    input  logic             wr,
    input  logic             wr_bad,
    input  logic [CNT_W-1:0] cnt_mid,
    output logic [IDX_W-1:0] cur_idx,
    output logic             cur_bad
);
    localparam int SW = CNT_W + 1;

    typedef struct packed {
        logic [IDX_W-1:0]     cur;
        logic [MAX_BANKS-1:0] bad;
    } ring_t;

    ring_t                ring_d, ring_q;
    logic [IDX_W-1:0]     cur_a;
    logic [SW-1:0]        slot;
    logic [MAX_BANKS-1:0] hit;

    always_comb begin
        if (!adv) begin
            cur_a = ring_q.cur;
        end else if (SW'(ring_q.cur) + SW'(1) >= SW'(banks)) begin
            cur_a = '0;
        end else begin
            cur_a = ring_q.cur + IDX_W'(1);
        end
        slot = SW'(cur_a) + SW'(cnt_mid);
        if (slot >= SW'(banks)) begin
            slot = slot - SW'(banks);
        end
        if (slot >= SW'(banks)) begin
            slot = '0;
        end
    end

    for (genvar g = 0; g < MAX_BANKS; g++) begin : g_hit
        assign hit[g] = wr && (slot == SW'(g));
    end

    always_comb begin
        ring_d = ring_q;
        if (clr) begin
            ring_d = '0;
        end else begin
            ring_d.cur = cur_a;
            for (int b = 0; b < MAX_BANKS; b++) begin
                if (hit[b]) begin
                    ring_d.bad[b] = wr_bad;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ring_q <= '0;
        end else begin
            ring_q <= ring_d;
        end
    end

    assign cur_idx = ring_q.cur;
    assign cur_bad = ring_q.bad[ring_q.cur];

    AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ring_q.cur) < MAX_BANKS); // R12
    AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !clr) |=> $stable(ring_q.cur)); // R12
endmodule

// File: rtl/ep_bank_status.sv
module ep_bank_status #(
    parameter int MAX_BANKS = 3,
    localparam int CNT_W    = $clog2(MAX_BANKS + 1),
    localparam int IDX_W    = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ep_rst,
    input  logic                     ep_dis,
    input  logic                     cfg_dir_in,
    input  logic                     cfg_iso,
    input  logic [CNT_W-1:0]         cfg_banks,
    input  logic [ebsc_pkg::IRQ_W-1:0] irq_en,
    input  logic                     pk_stored,
    input  logic                     pk_tog_err,
    input  logic                     fw_rx_clr,
    input  logic                     fw_tx_set,
    input  logic                     fw_kill,
    input  logic                     in_token,
    output logic                     rx_ready,
    output logic                     tx_ready,
    output logic                     tx_complete,
    output logic                     kill_busy,
    output logic                     trans_err,
    output logic                     err_flow,
    output logic [CNT_W-1:0]         busy_cnt,
    output logic [IDX_W-1:0]         cur_bank,
    output logic [ebsc_pkg::IRQ_W-1:0] irq
);
    import ebsc_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0] busy;
        logic             rx_rdy;
        logic             tx_rdy;
        logic             tx_done;
        logic             kill;
        logic             err_fl;
        logic             txclr;
    } stat_t;

    stat_t            st_d, st_q;
    logic             clr;
    logic [CNT_W-1:0] banks;
    logic             out_en, in_en;
    logic             o_rel, o_acc, o_drop;
    logic [CNT_W-1:0] o_mid, o_nxt;
    logic             i_sent, i_under;
    logic [CNT_W-1:0] i_nxt;
    logic             cur_bad;

    always_comb begin
        int b;
        b = int'(cfg_banks);
        if (b < 1) b = 1;
        if (b > MAX_BANKS) b = MAX_BANKS;
        banks = CNT_W'(b);
    end

    assign clr    = ep_rst || ep_dis;
    assign out_en = !cfg_dir_in && !clr;
    assign in_en  = cfg_dir_in && !clr;

    ebsc_out_path #(.CNT_W(CNT_W)) u_out (
        .en(out_en), .busy_q(st_q.busy), .banks(banks),
        .pk_stored(pk_stored), .fw_rx_clr(fw_rx_clr),
        .rel(o_rel), .acc(o_acc), .drop(o_drop),
        .cnt_mid(o_mid), .cnt_nxt(o_nxt)
    );

    ebsc_in_path #(.CNT_W(CNT_W)) u_in (
        .en(in_en), .busy_q(st_q.busy), .banks(banks),
        .in_token(in_token), .kill_q(st_q.kill), .fw_tx_set(fw_tx_set),
        .sent(i_sent), .underrun(i_under), .cnt_nxt(i_nxt)
    );

    ebsc_bank_ring #(.MAX_BANKS(MAX_BANKS), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_ring (
        .clk(clk), .rst_n(rst_n), .clr(clr), .banks(banks),
        .adv(o_rel || i_sent), .wr(o_acc), .wr_bad(pk_tog_err),
        .cnt_mid(o_mid), .cur_idx(cur_bank), .cur_bad(cur_bad)
    );

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d = '0;
        end else begin
            st_d.busy    = cfg_dir_in ? i_nxt : o_nxt;
            st_d.rx_rdy  = !cfg_dir_in && (st_d.busy != '0);
            st_d.tx_rdy  = cfg_dir_in && (st_d.busy == banks);
            st_d.tx_done = st_q.tx_done || i_sent;
            st_d.kill    = cfg_dir_in && fw_kill && !st_q.kill;
            st_d.err_fl  = st_q.err_fl || (cfg_iso && (o_drop || i_under));
            st_d.txclr   = st_q.tx_rdy && !st_d.tx_rdy && i_sent;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_cnt    = st_q.busy;
    assign rx_ready    = st_q.rx_rdy;
    assign tx_ready    = st_q.tx_rdy;
    assign tx_complete = st_q.tx_done;
    assign kill_busy   = st_q.kill;
    assign err_flow    = st_q.err_fl;
    assign trans_err   = cfg_iso && !cfg_dir_in && (st_q.busy != '0) && cur_bad;

    always_comb begin
        irq              = '0;
        irq[IRQ_RX]      = irq_en[IRQ_RX]      && st_q.rx_rdy;
        irq[IRQ_TXRDY]   = irq_en[IRQ_TXRDY]   && st_q.txclr;
        irq[IRQ_TXDONE]  = irq_en[IRQ_TXDONE]  && st_q.tx_done;
        irq[IRQ_TRERR]   = irq_en[IRQ_TRERR]   && trans_err;
        irq[IRQ_ERRFLOW] = irq_en[IRQ_ERRFLOW] && st_q.err_fl;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (busy_cnt == '0 && !rx_ready && !tx_ready && !tx_complete
                 && !kill_busy && !err_flow)); // R1
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.busy) <= MAX_BANKS); // R4
    AST_RX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_dir_in && !clr && fw_rx_clr && int'(st_q.busy) >= 2) |=> rx_ready); // R3
    AST_KILL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.kill |=> !st_q.kill); // R8
    AST_SEND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && !clr && in_token && st_q.busy != '0) |=> tx_complete); // R7
    AST_UNDERRUN_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_dir_in && cfg_iso && !clr && in_token && st_q.busy == '0) |=> err_flow); // R10
    AST_TXRDY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.txclr |-> (!st_q.tx_rdy && $past(st_q.tx_rdy))); // R13
endmodule

// File: tb/ep_bank_status_tb.sv
module ep_bank_status_tb;
    localparam int NB = 3;
    localparam int CW = 2;
    localparam int IW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ep_rst = 0, ep_dis = 0, cfg_dir_in = 0, cfg_iso = 0;
    logic [CW-1:0] cfg_banks = 2'd3;
    logic [4:0] irq_en = 5'h1f;
    logic pk_stored = 0, pk_tog_err = 0, fw_rx_clr = 0, fw_tx_set = 0, fw_kill = 0, in_token = 0;
    logic rx_ready, tx_ready, tx_complete, kill_busy, trans_err, err_flow;
    logic [CW-1:0] busy_cnt;
    logic [IW-1:0] cur_bank;
    logic [4:0] irq;

    always #2.5 clk = ~clk;

    ep_bank_status #(.MAX_BANKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .ep_rst(ep_rst), .ep_dis(ep_dis),
        .cfg_dir_in(cfg_dir_in), .cfg_iso(cfg_iso), .cfg_banks(cfg_banks),
        .irq_en(irq_en), .pk_stored(pk_stored), .pk_tog_err(pk_tog_err),
        .fw_rx_clr(fw_rx_clr), .fw_tx_set(fw_tx_set), .fw_kill(fw_kill),
        .in_token(in_token), .rx_ready(rx_ready), .tx_ready(tx_ready),
        .tx_complete(tx_complete), .kill_busy(kill_busy), .trans_err(trans_err),
        .err_flow(err_flow), .busy_cnt(busy_cnt), .cur_bank(cur_bank), .irq(irq)
    );

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    // reference model
    int m_busy, m_cur, m_rx, m_tx, m_done, m_kill, m_err, m_pulse;
    int m_bad[NB];

    function automatic int eff_banks(input int c);
        if (c < 1) return 1;
        if (c > NB) return NB;
        return c;
    endfunction

    function automatic int wrap_next(input int c, input int nb);
        return (c + 1 < nb) ? c + 1 : 0;
    endfunction

    task automatic model_clear();
        m_busy = 0; m_cur = 0; m_rx = 0; m_tx = 0; m_done = 0;
        m_kill = 0; m_err = 0; m_pulse = 0;
        for (int k = 0; k < NB; k++) m_bad[k] = 0;
    endtask

    task automatic model_step();
        int nb, b, snt;
        nb = eff_banks(int'(cfg_banks));
        if (ep_rst || ep_dis) begin
            model_clear();
        end else if (cfg_dir_in) begin
            snt = (in_token && m_busy > 0) ? 1 : 0;
            if (in_token && m_busy == 0 && cfg_iso) m_err = 1;
            b = m_busy - snt;
            if (snt == 1) m_cur = wrap_next(m_cur, nb);
            if (m_kill == 1 && b > 0) b = b - 1;
            if (fw_tx_set && b < nb) b = b + 1;
            m_pulse = (m_tx == 1 && snt == 1 && b != nb) ? 1 : 0;
            m_tx = (b == nb) ? 1 : 0;
            m_rx = 0;
            if (snt == 1) m_done = 1;
            m_kill = (fw_kill && m_kill == 0) ? 1 : 0;
            m_busy = b;
        end else begin
            b = m_busy;
            if (fw_rx_clr && b > 0) begin
                b = b - 1;
                m_cur = wrap_next(m_cur, nb);
            end
            if (pk_stored) begin
                if (b < nb) begin
                    m_bad[(m_cur + b) % nb] = pk_tog_err ? 1 : 0;
                    b = b + 1;
                end else if (cfg_iso) begin
                    m_err = 1;
                end
            end
            m_busy = b; m_rx = (b > 0) ? 1 : 0; m_tx = 0; m_kill = 0; m_pulse = 0;
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int te, ir;
        te = (cfg_iso && !cfg_dir_in && m_busy > 0 && m_bad[m_cur] == 1) ? 1 : 0;
        ir = 0;
        if (irq_en[0] && m_rx == 1)    ir |= 1;
        if (irq_en[1] && m_pulse == 1) ir |= 2;
        if (irq_en[2] && m_done == 1)  ir |= 4;
        if (irq_en[3] && te == 1)      ir |= 8;
        if (irq_en[4] && m_err == 1)   ir |= 16;
        chk("R4",  "busy_cnt",    int'(busy_cnt), m_busy);
        chk("R12", "cur_bank",    int'(cur_bank), m_cur);
        chk("R3",  "rx_ready",    int'(rx_ready), m_rx);
        chk("R6",  "tx_ready",    int'(tx_ready), m_tx);
        chk("R7",  "tx_complete", int'(tx_complete), m_done);
        chk("R8",  "kill_busy",   int'(kill_busy), m_kill);
        chk("R11", "trans_err",   int'(trans_err), te);
        chk("R10", "err_flow",    int'(err_flow), m_err);
        chk("R13", "irq",         int'(irq), ir);
    endtask

    task automatic idle_inputs();
        ep_rst = 0; ep_dis = 0; pk_stored = 0; pk_tog_err = 0;
        fw_rx_clr = 0; fw_tx_set = 0; fw_kill = 0; in_token = 0;
    endtask

    // inputs are set at a falling edge; one clock later the outputs are compared
    task automatic tick();
        model_step();
        @(posedge clk);
        @(negedge clk);
        compare_all();
        idle_inputs();
    endtask

    task automatic set_cfg(input int banks, input bit dir, input bit iso);
        cfg_banks = CW'(banks); cfg_dir_in = dir; cfg_iso = iso; ep_dis = 1;
        tick();
    endtask

    initial begin
        #(5ns * 200000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int seed;
        int v;
        seed = 32'h5eed_0042;
        v = $urandom(seed);
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        compare_all();
        chk("R1", "reset busy", int'(busy_cnt), 0);
        chk("R1", "reset irq", int'(irq), 0);

        // R2/R3/R4/R5: OUT, two banks, non-iso then iso overflow
        set_cfg(2, 0, 0);
        pk_stored = 1; tick();
        chk("R2", "rx after store", int'(rx_ready), 1);
        pk_stored = 1; tick();
        pk_stored = 1; tick();
        chk("R4", "count saturates", int'(busy_cnt), 2);
        chk("R5", "no err non-iso", int'(err_flow), 0);
        fw_rx_clr = 1; tick();
        chk("R3", "rx held", int'(rx_ready), 1);
        fw_rx_clr = 1; tick();
        chk("R3", "rx drops", int'(rx_ready), 0);
        chk("R12", "wrap at 2", int'(cur_bank), 0);
        set_cfg(0, 0, 1);
        pk_stored = 1; pk_tog_err = 1; tick();
        chk("R11", "bad group", int'(trans_err), 1);
        pk_stored = 1; tick();
        chk("R4", "banks 0 clamps", int'(busy_cnt), 1);
        chk("R5", "iso overflow", int'(err_flow), 1);
        fw_rx_clr = 1; pk_stored = 1; tick();
        chk("R11", "good group", int'(trans_err), 0);
        ep_rst = 1; pk_stored = 1; tick();
        chk("R1", "ep_rst clears", int'(busy_cnt) + int'(err_flow), 0);

        // R6..R10: IN, three banks, iso
        set_cfg(3, 1, 1);
        in_token = 1; tick();
        chk("R10", "underflow", int'(err_flow), 1);
        fw_tx_set = 1; tick();
        chk("R6", "not full", int'(tx_ready), 0);
        fw_tx_set = 1; tick();
        fw_tx_set = 1; tick();
        chk("R6", "full", int'(tx_ready), 1);
        fw_kill = 1; tick();
        chk("R8", "kill pending", int'(kill_busy), 1);
        in_token = 1; fw_kill = 1; tick();
        chk("R9", "send+kill", int'(busy_cnt), 1);
        chk("R8", "kill self clears", int'(kill_busy), 0);
        chk("R13", "txrdy pulse", int'(irq[1]), 1);
        fw_kill = 1; tick();
        in_token = 1; tick();
        chk("R9", "refused kill", int'(busy_cnt), 0);
        chk("R7", "complete", int'(tx_complete), 1);
        fw_kill = 1; tick();
        tick();
        chk("R8", "empty kill", int'(busy_cnt), 0);
        set_cfg(1, 1, 0);
        fw_tx_set = 1; tick();
        chk("R6", "single full", int'(tx_ready), 1);
        fw_kill = 1; tick();
        tick();
        chk("R8", "kill removes", int'(busy_cnt), 0);

        // constrained random phases
        for (int p = 0; p < 16; p++) begin
            set_cfg(p % 4, p[2], p[3]);
            for (int c = 0; c < 1500; c++) begin
                if (c % 50 == 0) irq_en = 5'($urandom);
                pk_stored  = ($urandom % 3) == 0;
                pk_tog_err = ($urandom % 4) == 0;
                fw_rx_clr  = ($urandom % 3) == 0;
                fw_tx_set  = ($urandom % 3) == 0;
                fw_kill    = ($urandom % 5) == 0;
                in_token   = ($urandom % 3) == 0;
                ep_rst     = ($urandom % 97) == 0;
                tick();
            end
        end

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule